// File: doc/BRIEF.md
# ATA Multiword DMA Word Sequencer

This block is the host side of an ATA multiword DMA burst. It waits for the device to raise its DMA request, then drives the active-low acknowledge and moves one 16-bit word per strobe. Writes use the write strobe and drive the bus. Reads use the read strobe and latch the bus. The burst goes on word after word while the device keeps its request up. Once the request falls, or once the write side runs out of data, the acknowledge is released after one more setup-length wait.

Phase lengths come from a 32-bit timing word that holds three cycle counts. Each count is the required time divided by the clock period. When the division is exact, one is subtracted; when there is a remainder, the quotient is kept as it is. At a 10 ns clock, a 50 ns setup, a 215 ns strobe and a 265 ns recovery pack to 0x0001A154.

On the user side there is a valid/ready port for outbound words, a one-cycle valid pulse for inbound words, and a direction select. The direction select is sampled when a burst begins.

Top module: `mdma_seq`

## Requirements
- R1: While reset (synchronous, active high) is applied, and after it is released with no request, dmack_n_o, dior_n_o, diow_n_o, cs0_n_o and cs1_n_o are 1, dd_oe_o is 0 and rx_valid_o is 0.
- R2: A burst begins only when the request, after a two-flop synchronizer, is high. In the write direction (dir_wr_i=1) a word must also be offered on tx_valid_i. When the burst begins, dmack_n_o goes to 0. Both chip selects stay at 1 throughout.
- R3: The timing word sampled when a burst begins holds the setup count in bits [3:0], the strobe count in bits [11:4] and the recovery count in bits [19:12]. Bits [31:20] are ignored. Each phase lasts its count plus one cycles, so a count of 0 still gives one cycle.
- R4: The first strobe of a burst goes low tm+1 cycles after dmack_n_o goes low.
- R5: Each strobe stays low for td+1 cycles. Only the strobe that belongs to the latched direction ever goes low.
- R6: While the request stays high, the next strobe goes low teoc+1+tm+1 cycles after the previous strobe is released.
- R7: If the request is low when the recovery phase ends, dmack_n_o returns to 1 teoc+1+tm+1 cycles after the last strobe is released.
- R8: In the write direction, a word is taken on a cycle with tx_valid_i and tx_ready_o both high. It is driven on dd_o with dd_oe_o=1 through the setup and strobe phases, and it stays stable while diow_n_o is low.
- R9: In the read direction, dd_i is latched in the last cycle of the strobe. The latched value is shown on rx_data_o with rx_valid_o=1 for exactly one cycle, the first cycle after dior_n_o returns to 1. dd_oe_o stays 0.
- R10: In the write direction, if no word is offered when the recovery phase ends, the burst ends as in R7. No new burst starts until a word is offered, even if the request is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| timing_i | input | 32 | Packed phase counts, sampled at burst start |
| dir_wr_i | input | 1 | 1 = host writes to device, 0 = host reads |
| tx_data_i | input | 16 | Outbound word |
| tx_valid_i | input | 1 | Outbound word offered |
| tx_ready_o | output | 1 | Outbound word taken this cycle |
| rx_data_o | output | 16 | Latched inbound word |
| rx_valid_o | output | 1 | One-cycle pulse: rx_data_o is new |
| dmarq_i | input | 1 | Device DMA request (asynchronous) |
| dmack_n_o | output | 1 | DMA acknowledge, active low |
| cs0_n_o | output | 1 | Chip select 0, active low, held inactive |
| cs1_n_o | output | 1 | Chip select 1, active low, held inactive |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |
| dd_o | output | 16 | Data bus, outbound |
| dd_i | input | 16 | Data bus, inbound |
| dd_oe_o | output | 1 | Data bus output enable |

## Verification
A phase counter that stops at the wrong value shows up within a single burst: a setup, strobe or recovery interval at the ports is one or more cycles off. The bench measures every such interval by counting cycles between edges of dmack_n_o and the strobes. If the sequencer took the wrong branch at the end of recovery, the strobe count for the burst would be wrong, or the acknowledge would be released early or late; both are seen at once. A bad data path shows as a wrong word on dd_o while the strobe is low, or as a wrong or missing rx_valid_o pulse in the first cycle after the read strobe is released.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
    localparam int WORD_W   = 32;
    localparam int TM_LSB   = 0;
    localparam int TM_W     = 4;
    localparam int TD_LSB   = 4;
    localparam int TD_W     = 8;
    localparam int TEOC_LSB = 12;
    localparam int TEOC_W   = 8;
    localparam int PH_W     = (TD_W > TEOC_W) ? TD_W : TEOC_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOV,
        ST_TAIL
    } mdma_state_e;

    typedef struct packed {
        logic [TM_W-1:0]   tm;
        logic [TD_W-1:0]   td;
        logic [TEOC_W-1:0] teoc;
    } mdma_timing_t;

    function automatic mdma_timing_t unpack_timing(input logic [WORD_W-1:0] w);
        mdma_timing_t t;
        t.tm   = w[TM_LSB +: TM_W];
        t.td   = w[TD_LSB +: TD_W];
        t.teoc = w[TEOC_LSB +: TEOC_W];
        return t;
    endfunction
endpackage

// File: rtl/mdma_sync.sv
module mdma_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/mdma_phase_timer.sv
module mdma_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clear_i ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == limit_i);

    // the sequencer must close a phase when its count is reached
    AST_PHASE_CLOSED: assert property (@(posedge clk) disable iff (rst)
        done_o |-> clear_i) else $error("phase ran past its count"); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> (cnt_q != '0)) else $error("phase counter wrapped"); // R3
endmodule

// File: rtl/mdma_seq.sv
module mdma_seq
    import mdma_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] timing_i,
    input  logic              dir_wr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic              dmarq_i,
    output logic              dmack_n_o,
    output logic              cs0_n_o,
    output logic              cs1_n_o,
    output logic              dior_n_o,
    output logic              diow_n_o,
    output logic [DATA_W-1:0] dd_o,
    input  logic [DATA_W-1:0] dd_i,
    output logic              dd_oe_o
);
    typedef struct packed {
        mdma_state_e       st;
        logic              wr;
        mdma_timing_t      tim;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic            req_s;
    logic            ph_done;
    logic            ph_clear;
    logic [PH_W-1:0] ph_limit;
    logic            take_word;

    mdma_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
        .clk (clk),
        .rst (rst),
        .d_i (dmarq_i),
        .q_o (req_s)
    );

    mdma_phase_timer #(.CNT_W(PH_W)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .clear_i (ph_clear),
        .limit_i (ph_limit),
        .done_o  (ph_done)
    );

    always_comb begin
        case (r_q.st)
            ST_SETUP, ST_TAIL: ph_limit = PH_W'(r_q.tim.tm);
            ST_STROBE:         ph_limit = PH_W'(r_q.tim.td);
            ST_RECOV:          ph_limit = PH_W'(r_q.tim.teoc);
            default:           ph_limit = '0;
        endcase
    end

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        ph_clear   = 1'b0;
        take_word  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                ph_clear = 1'b1;
                if (req_s && (!dir_wr_i || tx_valid_i)) begin
                    r_d.st    = ST_SETUP;
                    r_d.wr    = dir_wr_i;
                    r_d.tim   = unpack_timing(timing_i);
                    take_word = dir_wr_i;
                end
            end
            ST_SETUP: begin
                if (ph_done) begin
                    ph_clear = 1'b1;
                    r_d.st   = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (ph_done) begin
                    ph_clear = 1'b1;
                    r_d.st   = ST_RECOV;
                    if (!r_q.wr) begin
                        r_d.rdata  = dd_i;
                        r_d.rvalid = 1'b1;
                    end
                end
            end
            ST_RECOV: begin
                if (ph_done) begin
                    ph_clear = 1'b1;
                    if (req_s && (!r_q.wr || tx_valid_i)) begin
                        r_d.st    = ST_SETUP;
                        take_word = r_q.wr;
                    end else begin
                        r_d.st = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (ph_done) begin
                    ph_clear = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: begin
                ph_clear = 1'b1;
                r_d.st   = ST_IDLE;
            end
        endcase
        if (take_word) r_d.wdata = tx_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st     <= ST_IDLE;
            r_q.wr     <= 1'b0;
            r_q.tim    <= '0;
            r_q.wdata  <= '0;
            r_q.rdata  <= '0;
            r_q.rvalid <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_ready_o = take_word;
    assign rx_data_o  = r_q.rdata;
    assign rx_valid_o = r_q.rvalid;
    assign dmack_n_o  = (r_q.st == ST_IDLE);
    assign cs0_n_o    = 1'b1;
    assign cs1_n_o    = 1'b1;
    assign dior_n_o   = !((r_q.st == ST_STROBE) && !r_q.wr);
    assign diow_n_o   = !((r_q.st == ST_STROBE) && r_q.wr);
    assign dd_o       = r_q.wdata;
    assign dd_oe_o    = r_q.wr && ((r_q.st == ST_SETUP) || (r_q.st == ST_STROBE));

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        dior_n_o || diow_n_o) else $error("both strobes low"); // R5
    AST_STROBE_UNDER_ACK: assert property (@(posedge clk) disable iff (rst)
        (!dior_n_o || !diow_n_o) |-> !dmack_n_o) else $error("strobe without ack"); // R2
    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        dd_oe_o |-> (!dmack_n_o && dior_n_o)) else $error("bus driven outside write"); // R9
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        !diow_n_o |=> (diow_n_o || $stable(dd_o))) else $error("data moved under strobe"); // R8
    AST_RX_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o) else $error("read valid longer than a cycle"); // R9
    AST_RX_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> ($past(!dior_n_o) && dior_n_o)) else $error("read valid misplaced"); // R9
    AST_ACK_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(dmack_n_o) |-> (dior_n_o && diow_n_o && !dd_oe_o)) else $error("ack dropped mid word"); // R7
endmodule

// File: tb/test_mdma_seq.sv
`timescale 1ns/1ps
module test_mdma_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] timing = '0;
    logic        dir_wr = 1'b0;
    logic [15:0] tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic [15:0] rx_data;
    logic        rx_valid;
    logic        dmarq = 1'b0;
    logic        dmack_n, cs0_n, cs1_n, dior_n, diow_n, dd_oe;
    logic [15:0] dd_out;
    logic [15:0] dd_in = '0;

    int hs = 0;
    int avail_lim = 0;
    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    assign tx_valid = (hs < avail_lim);
    assign tx_data  = 16'h5000 + 16'(hs);

    always @(posedge clk) begin
        if (tx_valid && tx_ready) hs <= hs + 1;
    end

    mdma_seq i_mdma_seq (
        .clk        (clk),
        .rst        (rst),
        .timing_i   (timing),
        .dir_wr_i   (dir_wr),
        .tx_data_i  (tx_data),
        .tx_valid_i (tx_valid),
        .tx_ready_o (tx_ready),
        .rx_data_o  (rx_data),
        .rx_valid_o (rx_valid),
        .dmarq_i    (dmarq),
        .dmack_n_o  (dmack_n),
        .cs0_n_o    (cs0_n),
        .cs1_n_o    (cs1_n),
        .dior_n_o   (dior_n),
        .diow_n_o   (diow_n),
        .dd_o       (dd_out),
        .dd_i       (dd_in),
        .dd_oe_o    (dd_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(dmack_n && dior_n && diow_n && cs0_n && cs1_n && !dd_oe && !rx_valid,
              "R1", "lines during reset", {dmack_n, dior_n, diow_n, cs0_n, cs1_n, dd_oe, rx_valid}, 7'b1111100);
        @(negedge clk) rst = 1'b0;
        repeat (6) @(negedge clk);
        check(dmack_n && dior_n && diow_n && cs0_n && cs1_n && !dd_oe && !rx_valid,
              "R1", "lines idle after reset", {dmack_n, dior_n, diow_n, cs0_n, cs1_n, dd_oe, rx_valid}, 7'b1111100);
    endtask

    task automatic test_no_request();
        int acks = 0;
        dir_wr = 1'b0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (!dmack_n) acks++;
        end
        check(acks == 0, "R2", "ack without request", acks, 0);
    endtask

    // One burst; the request drops on the first cycle of the last expected strobe.
    task automatic run_burst(input bit wr, input int nwords, input int avail,
                             input logic [31:0] tword, input string tag);
        int tm = int'(tword[3:0]);
        int td = int'(tword[11:4]);
        int teoc = int'(tword[19:12]);
        int base = hs;
        int expw = (wr && avail < nwords) ? avail : nwords;
        int strobes = 0, rxv = 0, t_ack = 0, t_lo = 0, t_hi = 0;
        int bad_wd = 0, bad_oe = 0, bad_other = 0, bad_cs = 0;
        bit prev_s = 1'b0, prev_ack = 1'b0, done = 1'b0, s_lo, ack_lo;
        timing = tword;
        dir_wr = wr;
        avail_lim = wr ? base + avail : base;
        @(negedge clk) dmarq = 1'b1;
        for (int c = 0; c < 3000 && !done; c++) begin
            @(negedge clk);
            s_lo   = wr ? !diow_n : !dior_n;
            ack_lo = !dmack_n;
            if (wr ? !dior_n : !diow_n) bad_other++;
            if (!cs0_n || !cs1_n) bad_cs++;
            if (!wr && dd_oe) bad_oe++;
            if (ack_lo && !prev_ack) t_ack = c;
            if (s_lo && !prev_s) begin
                strobes++;
                t_lo = c;
                if (strobes == 1)
                    check(c - t_ack == tm + 1, "R4", {tag, " setup before first strobe"}, c - t_ack, tm + 1);
                else
                    check(c - t_hi == teoc + tm + 2, "R6", {tag, " gap between strobes"}, c - t_hi, teoc + tm + 2);
                if (!wr) dd_in = 16'hA000 + 16'(strobes);
                if (strobes == nwords) dmarq = 1'b0;
            end
            if (s_lo && wr && (dd_out != 16'h5000 + 16'(base + strobes - 1) || !dd_oe)) bad_wd++;
            if (!s_lo && prev_s) begin
                check(c - t_lo == td + 1, "R5", {tag, " strobe width"}, c - t_lo, td + 1);
                t_hi = c;
                if (!wr)
                    check(rx_valid && rx_data == 16'hA000 + 16'(strobes), "R9",
                          {tag, " read word after strobe"}, int'(rx_data), int'(16'hA000 + 16'(strobes)));
            end
            if (rx_valid) rxv++;
            if (!ack_lo && prev_ack) begin
                check(c - t_hi == teoc + tm + 2, "R7", {tag, " ack release after last strobe"}, c - t_hi, teoc + tm + 2);
                done = 1'b1;
            end
            prev_s = s_lo;
            prev_ack = ack_lo;
        end
        check(done, "R7", {tag, " burst finished"}, int'(done), 1);
        check(strobes == expw, wr ? "R8" : "R9", {tag, " words moved"}, strobes, expw);
        check(rxv == (wr ? 0 : expw), "R9", {tag, " read valid pulses"}, rxv, wr ? 0 : expw);
        check(bad_other == 0, "R5", {tag, " opposite strobe low"}, bad_other, 0);
        check(bad_cs == 0, "R2", {tag, " chip select low"}, bad_cs, 0);
        if (wr) check(bad_wd == 0, "R8", {tag, " write data or enable wrong"}, bad_wd, 0);
        else    check(bad_oe == 0, "R9", {tag, " bus enabled on read"}, bad_oe, 0);
    endtask

    task automatic test_write_basic();
        run_burst(1'b1, 3, 3, {12'h000, 8'd1, 8'd3, 4'd2}, "write3");
        repeat (4) @(negedge clk);
    endtask

    task automatic test_read_basic();
        run_burst(1'b0, 3, 0, {12'h000, 8'd2, 8'd2, 4'd1}, "read3");
        repeat (4) @(negedge clk);
    endtask

    task automatic test_worked_word();
        // R3: 0x0001A154 -> setup 4, strobe 0x15, recovery 0x1a
        run_burst(1'b0, 2, 0, 32'h0001A154, "worked_read");
        repeat (4) @(negedge clk);
        // R3: reserved bits [31:20] set must not change the timing
        run_burst(1'b1, 2, 2, 32'hFFF1A154, "reserved_write");
        repeat (4) @(negedge clk);
    endtask

    task automatic test_zero_fields();
        // R3: zero counts give one-cycle phases
        run_burst(1'b1, 4, 4, {12'h000, 8'd0, 8'd1, 4'd0}, "zero_write");
        repeat (4) @(negedge clk);
        run_burst(1'b0, 1, 0, {12'h000, 8'd1, 8'd0, 4'd0}, "single_read");
        repeat (4) @(negedge clk);
    endtask

    task automatic test_starve();
        int acks = 0;
        // R10: request held, only two words offered
        run_burst(1'b1, 99, 2, {12'h000, 8'd1, 8'd2, 4'd1}, "starve_write");
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (!dmack_n) acks++;
        end
        check(acks == 0, "R10", "restart without a word", acks, 0);
        dmarq = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        test_reset();
        test_no_request();
        test_write_basic();
        test_read_basic();
        test_worked_word();
        test_zero_fields();
        test_starve();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule